// File: doc/BRIEF.md
# Stream Beat Clock-Domain Bridge

This block moves single data beats of a valid/ready stream from one clock domain into a second, unrelated clock domain. There is no dual-clock FIFO. The source side latches one beat into a holding register and flips a request toggle. The destination side synchronises that toggle, sees that it has changed, captures the held word and raises its valid output. When the consumer takes the beat, the destination flips an acknowledge toggle. The source synchronises that toggle back, and the source reopens once the two toggles agree again.

Only one beat is ever in flight. Throughput is therefore bounded by one round trip through both synchronisers. In return the cost is one payload register on each side, four control flops and two short synchronisers. The path from acceptance to destination valid is kept as short as the two-flop synchroniser allows. The design fits links that are narrow in rate but may be wide in payload, such as control words and configuration beats. Both domains share one active-low asynchronous reset.

Top module: `xclk_axis_bridge`

## Requirements
- R1: While `rst_n` is low and after its release, `s_ready` is high, `m_valid` is low, and both toggles are zero.
- R2: A source beat is taken on a `s_clk` rising edge where `s_valid` and `s_ready` are both high. `s_ready` is low on the following source cycle.
- R3: The held source word does not change while `s_ready` is low.
- R4: `m_valid` rises at the third `m_clk` rising edge after the source acceptance edge. `m_data` then equals the accepted `s_data`.
- R5: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays unchanged.
- R6: A beat is consumed on an `m_clk` rising edge where `m_valid` and `m_ready` are both high. `m_valid` is low after that edge, and `s_ready` is high again after the second `s_clk` rising edge that follows.
- R7: A beat offered with `s_valid` high while `s_ready` is low is ignored. It is never delivered.
- R8: Under arbitrary source and destination stalls, every accepted beat is delivered exactly once, in order, with nothing lost.
- R9: The payload width is the parameter `DATA_W`, defaulting to 512. No sideband signals are carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| s_clk | input | 1 | Source-domain clock |
| s_valid | input | 1 | Source beat offered |
| s_ready | output | 1 | Bridge can take a source beat |
| s_data | input | DATA_W | Source payload |
| m_clk | input | 1 | Destination-domain clock |
| m_valid | output | 1 | Destination beat available |
| m_ready | input | 1 | Destination consumer takes the beat |
| m_data | output | DATA_W | Destination payload |

## Verification
Destination valid is due at the third `m_clk` edge after the source acceptance edge. After a destination acceptance, valid is gone at the next `m_clk` edge, and `s_ready` returns at the second `s_clk` edge. The bench runs 20 ns and 13 ns clocks whose edges never coincide. It drives and samples 0.1 ns after an edge and counts the receiving clock's edges from the stimulus edge, so each latency is compared against an exact count rather than a window. The stall and stream scenarios then check stability, ignored offers and exact-once ordering at the ports.

// File: rtl/xclk_pkg.sv
package xclk_pkg;

    // Synchroniser depth used by both crossing directions.
    localparam int unsigned SYNC_DEPTH = 2;

    // A toggle pair differs when one side has posted a change that the
    // other side has not yet consumed.
    function automatic logic toggle_pending(input logic posted, input logic seen);
        return posted ^ seen;
    endfunction

    // Destination-side control state.
    typedef struct packed {
        logic valid;
        logic seen;
        logic ack;
    } dst_ctrl_t;

endpackage

// File: rtl/xclk_sync.sv
module xclk_sync #(
    parameter int unsigned STAGES = xclk_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xclk_src.sv
module xclk_src
    import xclk_pkg::*;
#(
    parameter int unsigned DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              ack_sync,
    output logic              req_tgl,
    output logic [DATA_W-1:0] hold_data
);
    logic take;

    assign s_ready = !toggle_pending(req_tgl, ack_sync);
    assign take    = s_valid && s_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl   <= 1'b0;
            hold_data <= '0;
        end else if (take) begin
            req_tgl   <= ~req_tgl;
            hold_data <= s_data;
        end
    end
endmodule

// File: rtl/xclk_dst.sv
module xclk_dst
    import xclk_pkg::*;
#(
    parameter int unsigned DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  logic [DATA_W-1:0] hold_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              ack_tgl
);
    dst_ctrl_t ctrl_q, ctrl_d;
    logic [DATA_W-1:0] data_q;
    logic load;

    always_comb begin
        ctrl_d = ctrl_q;
        load   = 1'b0;
        if (!ctrl_q.valid && toggle_pending(req_sync, ctrl_q.seen)) begin
            ctrl_d.valid = 1'b1;
            ctrl_d.seen  = req_sync;
            load         = 1'b1;
        end else if (ctrl_q.valid && m_ready) begin
            ctrl_d.valid = 1'b0;
            ctrl_d.ack   = ~ctrl_q.ack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (load) data_q <= hold_data;
        end
    end

    assign m_valid = ctrl_q.valid;
    assign m_data  = data_q;
    assign ack_tgl = ctrl_q.ack;
endmodule

// File: rtl/xclk_axis_bridge.sv
module xclk_axis_bridge #(
    parameter int unsigned DATA_W = 512
) (
    input  logic              rst_n,
    input  logic              s_clk,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              m_clk,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data
);
    logic              req_tgl, req_sync;
    logic              ack_tgl, ack_sync;
    logic [DATA_W-1:0] xfer_data;

    xclk_src #(.DATA_W(DATA_W)) u_src (
        .clk       (s_clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_data    (s_data),
        .ack_sync  (ack_sync),
        .req_tgl   (req_tgl),
        .hold_data (xfer_data)
    );

    xclk_sync u_req_sync (
        .clk   (m_clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_sync)
    );

    xclk_dst #(.DATA_W(DATA_W)) u_dst (
        .clk       (m_clk),
        .rst_n     (rst_n),
        .req_sync  (req_sync),
        .hold_data (xfer_data),
        .m_valid   (m_valid),
        .m_ready   (m_ready),
        .m_data    (m_data),
        .ack_tgl   (ack_tgl)
    );

    xclk_sync u_ack_sync (
        .clk   (s_clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_sync)
    );
endmodule

// File: rtl/xclk_axis_bridge_chk.sv
module xclk_axis_bridge_chk #(
    parameter int unsigned DATA_W = 512
) (
    input logic              rst_n,
    input logic              s_clk,
    input logic              s_valid,
    input logic              s_ready,
    input logic              m_clk,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic [DATA_W-1:0] xfer_data,
    input logic              req_tgl,
    input logic              ack_tgl
);
    // R1: reset state seen from both domains
    always @(posedge s_clk) begin
        if (!rst_n) begin
            a_r1_reset_state : assert (s_ready && !m_valid && !req_tgl && !ack_tgl);
        end
    end

    // R2: acceptance closes the source side for the next cycle
    a_r2_close_after_take : assert property (@(posedge s_clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);

    // R3: held word is frozen while a beat is in flight
    a_r3_hold_stable : assert property (@(posedge s_clk) disable iff (!rst_n)
        (!s_ready && $past(!s_ready)) |-> $stable(xfer_data));

    // R5: destination beat held until taken
    a_r5_valid_hold : assert property (@(posedge m_clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R6: destination acceptance drops valid at the next edge
    a_r6_drop_after_take : assert property (@(posedge m_clk) disable iff (!rst_n)
        (m_valid && m_ready) |=> !m_valid);

    // R8: a new destination beat only appears when the request toggle moved
    a_r8_no_spurious : assert property (@(posedge m_clk) disable iff (!rst_n)
        $rose(m_valid) |-> (req_tgl != ack_tgl));
endmodule

bind xclk_axis_bridge xclk_axis_bridge_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_xclk_axis_bridge.sv
`timescale 1ns/10ps
module tb_xclk_axis_bridge;
    localparam int unsigned W = 32;
    localparam int unsigned N_STREAM = 60;

    logic          rst_n;
    logic          s_clk, m_clk;
    logic          s_valid, s_ready;
    logic [W-1:0]  s_data;
    logic          m_valid, m_ready;
    logic [W-1:0]  m_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    xclk_axis_bridge #(.DATA_W(W)) dut (
        .rst_n   (rst_n),
        .s_clk   (s_clk),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .s_data  (s_data),
        .m_clk   (m_clk),
        .m_valid (m_valid),
        .m_ready (m_ready),
        .m_data  (m_data)
    );

    // 50 MHz source clock, 13 ns destination clock offset so edges never meet
    initial begin s_clk = 0; forever #10 s_clk = ~s_clk; end
    initial begin m_clk = 0; #0.3; forever #6.5 m_clk = ~m_clk; end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Offer a beat until accepted; returns right after the accepting edge.
    task automatic src_push(input logic [W-1:0] val);
        bit was_ready;
        s_valid = 1; s_data = val;
        forever begin
            was_ready = s_ready;
            @(posedge s_clk);
            if (was_ready) break;
        end
        #0.1;
        s_valid = 0;
    endtask

    task automatic count_dst_until_valid(output int n);
        n = 0;
        while (!m_valid && n < 50) begin @(posedge m_clk); #0.1; n++; end
    endtask

    // Take the pending destination beat, then count source edges until ready.
    task automatic dst_take(output logic [W-1:0] got, output int n_src);
        @(posedge m_clk); #0.1;
        got = m_data;
        m_ready = 1;
        @(posedge m_clk); #0.1;
        m_ready = 0;
        check(!m_valid, "R6 valid low after take", m_valid, 0);
        n_src = 0;
        while (!s_ready && n_src < 50) begin @(posedge s_clk); #0.1; n_src++; end
    endtask

    task automatic t_reset();
        @(posedge s_clk); #0.1;
        check(s_ready == 1, "R1 s_ready in reset", s_ready, 1);
        check(m_valid == 0, "R1 m_valid in reset", m_valid, 0);
        rst_n = 1;
        repeat (3) @(posedge m_clk);
        #0.1;
        check(s_ready == 1, "R1 s_ready after reset", s_ready, 1);
        check(m_valid == 0, "R1 m_valid after reset", m_valid, 0);
    endtask

    task automatic t_latency();
        int n; int ns; logic [W-1:0] got;
        src_push(32'hA5A5_0001);
        check(!s_ready, "R2 ready low after take", s_ready, 0);
        count_dst_until_valid(n);
        check(n == 3, "R4 dst edges to valid", n, 3);
        check(m_data == 32'hA5A5_0001, "R4 delivered data", m_data, 32'hA5A5_0001);
        dst_take(got, ns);
        check(ns == 2, "R6 src edges to ready", ns, 2);
    endtask

    task automatic t_stall_and_ignore();
        int n; int ns; logic [W-1:0] got;
        src_push(32'h1234_5678);
        // offer another beat while closed: must be ignored
        s_valid = 1; s_data = 32'hDEAD_BEEF;
        repeat (3) @(posedge s_clk);
        #0.1;
        s_valid = 0;
        count_dst_until_valid(n);
        check(n <= 3, "R4 valid during stall test", n, 3);
        for (int i = 0; i < 8; i++) begin
            @(posedge m_clk); #0.1;
            check(m_valid && m_data == 32'h1234_5678, "R5 held while stalled", m_data, 32'h1234_5678);
        end
        check(!s_ready, "R2 source closed while in flight", s_ready, 0);
        dst_take(got, ns);
        check(got == 32'h1234_5678, "R5 taken data", got, 32'h1234_5678);
        for (int i = 0; i < 12; i++) begin
            @(posedge m_clk); #0.1;
            check(!m_valid, "R7 ignored offer not delivered", m_valid, 0);
        end
    endtask

    task automatic t_stream();
        int rx = 0;
        fork
            begin
                for (int k = 0; k < N_STREAM; k++) begin
                    repeat ($urandom_range(0, 3)) @(posedge s_clk);
                    #0.1;
                    src_push(32'hC000_0000 + k);
                end
            end
            begin
                bit go; bit v;
                while (rx < N_STREAM) begin
                    #0.1;
                    go = ($urandom_range(0, 2) != 0);
                    m_ready = go;
                    v = m_valid;
                    @(posedge m_clk);
                    if (v && go) begin
                        check(m_data == 32'hC000_0000 + rx, "R8 order and value",
                              m_data, 32'hC000_0000 + rx);
                        rx++;
                    end
                end
                #0.1; m_ready = 0;
            end
        join
        for (int i = 0; i < 15; i++) begin
            @(posedge m_clk); #0.1;
            if (i == 14) check(!m_valid && s_ready, "R8 no duplicate after stream", m_valid, 0);
        end
        check(rx == N_STREAM, "R8 beat count", rx, N_STREAM);
    endtask

    task automatic t_width();
        // R9: full-width pattern crosses intact
        int n; int ns; logic [W-1:0] got;
        src_push('1);
        count_dst_until_valid(n);
        check(m_data == '1, "R9 full width data", m_data, 32'hFFFF_FFFF);
        dst_take(got, ns);
    endtask

    initial begin
        rst_n = 0; s_valid = 0; s_data = '0; m_ready = 0;
        t_reset();
        t_latency();
        t_stall_and_ignore();
        t_stream();
        t_width();
        finish_run();
    end

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule